// File: doc/BRIEF.md
# Per-Channel Frame Marker Tracker

This block follows the frame markers of a camera packet stream on several virtual channels at once. Every short packet comes in as a data type and a channel number. The block keeps track of whether each channel is inside a frame, which is the span from a Frame Start to the matching Frame End. It also collects the payload error pulses that arrive for that channel while the frame is open.

At each Frame End the block raises status bits. One bit says a frame ended. A per-channel bit says the end marker had no opening marker. A second per-channel bit says the closed frame carried damaged payload.

A synchronization failure at start of transmission carries no channel number. The block charges it to the channel of the most recent frame marker it accepted.

Every status bit is sticky. Software clears a bit by writing a one to its position, and a new event in the same cycle keeps the bit set.

Top module: `fst_frame_sync_tracker`

## Requirements
- R1: After reset, all status outputs are 0, every channel is outside a frame, and the most recent channel is 0.
- R2: A Frame End (data type 0x01) on a channel that is outside a frame sets that channel's bit in `sync_err`. A Frame End that closes a frame opened by a Frame Start (data type 0x00) on the same channel leaves `sync_err` alone.
- R3: A Frame End that closes a frame sets that channel's bit in `frame_err` exactly when at least one payload error for that channel arrived between the Frame Start cycle and the Frame End cycle, both cycles included. Errors that arrive while the channel is outside a frame are not counted.
- R4: A second Frame Start inside an open frame restarts the frame. Errors seen before that second Frame Start are dropped. An error in the same cycle as the second Frame Start is kept.
- R5: Repeated markers are still processed. A Frame End after a Frame End sets the sync bit and `frame_rcvd` again. A Frame Start after a Frame Start leaves the channel in a frame, and the following Frame End raises no sync error.
- R6: Channels are independent. Markers and payload errors on one channel never change the frame state, the error accumulation or the status bits of another channel.
- R7: A pulse on `sot_sync_err` sets the `sync_err` bit of the channel named by the most recent Frame Start or Frame End accepted in an earlier cycle. That channel is 0 if no marker has been seen. If that channel is in a frame, the pulse also counts as a payload error for it.
- R8: `frame_rcvd` is set by every Frame End on any channel.
- R9: A write with `wr_en` high clears each status bit whose `wr_data` bit is 1. The field positions are: bit 0 is `frame_rcvd`, bit 1+c is `sync_err[c]`, and bit NUM_VC+1+c is `frame_err[c]`. When a bit is set and cleared in the same cycle, the set wins. All status changes appear on the outputs one cycle after the event.
- R10: A short packet whose data type is neither 0x00 nor 0x01 changes no state. It does not alter any channel's frame state, and it does not move the most recent channel used by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_valid | input | 1 | Short packet present this cycle |
| sp_dtype | input | DT_W (6) | Short packet data type |
| sp_vc | input | VC_W (2) | Short packet virtual channel |
| perr_valid | input | 1 | Payload error pulse |
| perr_vc | input | VC_W (2) | Channel of the payload error |
| sot_sync_err | input | 1 | Start-of-transmission synchronization failure, no channel |
| wr_en | input | 1 | Status clear write strobe |
| wr_data | input | 2*NUM_VC+1 (9) | Write-one-to-clear mask, layout as in R9 |
| sync_err | output | NUM_VC (4) | Per-channel unpaired-marker status |
| frame_err | output | NUM_VC (4) | Per-channel damaged-frame status |
| frame_rcvd | output | 1 | Frame End received status |

## Verification
The bench drives pairs and repeats of markers. It checks that a Frame End after a Frame End is counted as unpaired, while a Frame Start after a Frame Start is not. A wrong pairing rule would flag good frames or miss broken ones.

It places error pulses while a channel is idle, before a restarting Frame Start, and in the same cycle as the Frame Start or Frame End. A design with misplaced accumulator clears would report stale or missing frame errors.

Synchronization failures are sent after an unrecognized data type, to catch a design that charges them to the wrong channel. Clears are written in the same cycle as sets, to catch a design that lets the clear win.

// File: rtl/fst_pkg.sv
package fst_pkg;

   // Per-channel stimulus decoded in the top level.
   typedef struct packed {
      logic fs;    // Frame Start for this channel
      logic fe;    // Frame End for this channel
      logic hit;   // payload error charged to this channel
   } fst_chan_ev_t;

   function automatic int unsigned fst_vc_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fst_w1c_bank.sv
module fst_w1c_bank #(
   parameter int unsigned WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("fst_w1c_bank: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic bit_q;

      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= set_i[b] | (bit_q & ~clr_i[b]);
      end

      assign q_o[b] = bit_q;

      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q_o[b]); // R9
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !q_o[b]); // R9
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[b] && q_o[b]) |=> q_o[b]); // R9
   end

endmodule

// File: rtl/fst_vc_tracker.sv
module fst_vc_tracker
   import fst_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  fst_chan_ev_t ev_i,
   output logic         sync_set_o,
   output logic         ferr_set_o
);

   logic in_frame_q;
   logic acc_q;
   logic acc_now;

   // Error seen so far in this frame, including this cycle.
   assign acc_now    = acc_q | (ev_i.hit & in_frame_q);
   assign sync_set_o = ev_i.fe & ~in_frame_q;
   assign ferr_set_o = ev_i.fe & in_frame_q & acc_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         acc_q      <= 1'b0;
      end else if (ev_i.fs) begin
         in_frame_q <= 1'b1;
         acc_q      <= ev_i.hit;
      end else if (ev_i.fe) begin
         in_frame_q <= 1'b0;
         acc_q      <= 1'b0;
      end else begin
         acc_q      <= acc_now;
      end
   end

   AST_FS_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i.fs |=> in_frame_q); // R5
   AST_FE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i.fe && !ev_i.fs) |=> !in_frame_q); // R2
   AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i.fs && !ev_i.hit) |=> !acc_q); // R4
   AST_IDLE_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame_q && !ev_i.fs) |=> !acc_q); // R3

endmodule

// File: rtl/fst_frame_sync_tracker.sv
module fst_frame_sync_tracker
   import fst_pkg::*;
#(
   parameter int unsigned NUM_VC  = 4,
   parameter int unsigned DT_W    = 6,
   parameter int unsigned FS_CODE = 0,
   parameter int unsigned FE_CODE = 1,
   localparam int unsigned VC_W   = fst_vc_width(NUM_VC),
   localparam int unsigned ST_W   = 2 * NUM_VC + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_valid,
   input  logic [DT_W-1:0]   sp_dtype,
   input  logic [VC_W-1:0]   sp_vc,
   input  logic              perr_valid,
   input  logic [VC_W-1:0]   perr_vc,
   input  logic              sot_sync_err,
   input  logic              wr_en,
   input  logic [ST_W-1:0]   wr_data,
   output logic [NUM_VC-1:0] sync_err,
   output logic [NUM_VC-1:0] frame_err,
   output logic              frame_rcvd
);

   localparam int unsigned RCVD_POS = 0;
   localparam int unsigned SYNC_LSB = 1;
   localparam int unsigned FERR_LSB = NUM_VC + 1;

   if (NUM_VC < 1) begin : g_bad_vc
      $error("fst_frame_sync_tracker: NUM_VC must be at least 1");
   end
   if (FS_CODE == FE_CODE) begin : g_bad_codes
      $error("fst_frame_sync_tracker: marker codes must differ");
   end
   if (FS_CODE >= (1 << DT_W) || FE_CODE >= (1 << DT_W)) begin : g_bad_dt
      $error("fst_frame_sync_tracker: marker code exceeds DT_W");
   end

   logic is_fs, is_fe;
   logic [VC_W-1:0]   last_vc_q;
   logic [NUM_VC-1:0] fs_vec, fe_vec;
   logic [NUM_VC-1:0] trk_sync, trk_ferr, sot_sync;
   logic [ST_W-1:0]   set_vec, clr_vec, st_q;

   assign is_fs = sp_valid && (sp_dtype == DT_W'(FS_CODE));
   assign is_fe = sp_valid && (sp_dtype == DT_W'(FE_CODE));

   // Most recent channel that carried a frame marker.
   always_ff @(posedge clk) begin
      if (!rst_n)              last_vc_q <= '0;
      else if (is_fs || is_fe) last_vc_q <= sp_vc;
   end

   for (genvar c = 0; c < NUM_VC; c++) begin : g_chan
      fst_chan_ev_t ev;
      logic sot_here;

      assign sot_here  = sot_sync_err && (last_vc_q == VC_W'(c));
      assign fs_vec[c] = is_fs && (sp_vc == VC_W'(c));
      assign fe_vec[c] = is_fe && (sp_vc == VC_W'(c));
      assign ev.fs     = fs_vec[c];
      assign ev.fe     = fe_vec[c];
      assign ev.hit    = (perr_valid && (perr_vc == VC_W'(c))) || sot_here;
      assign sot_sync[c] = sot_here;

      fst_vc_tracker u_trk (
         .clk        (clk),
         .rst_n      (rst_n),
         .ev_i       (ev),
         .sync_set_o (trk_sync[c]),
         .ferr_set_o (trk_ferr[c])
      );

      assign set_vec[SYNC_LSB + c] = trk_sync[c] | sot_sync[c];
      assign set_vec[FERR_LSB + c] = trk_ferr[c];
      assign sync_err[c]  = st_q[SYNC_LSB + c];
      assign frame_err[c] = st_q[FERR_LSB + c];
   end

   assign set_vec[RCVD_POS] = is_fe;
   assign clr_vec           = wr_en ? wr_data : '0;
   assign frame_rcvd        = st_q[RCVD_POS];

   fst_w1c_bank #(.WIDTH(ST_W)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .q_o   (st_q)
   );

   AST_FE_MARKS_RCVD: assert property (@(posedge clk) disable iff (!rst_n)
      is_fe |=> frame_rcvd); // R8
   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fs_vec | fe_vec)); // R6
   AST_SOT_CHARGED: assert property (@(posedge clk) disable iff (!rst_n)
      sot_sync_err |=> sync_err[$past(last_vc_q)]); // R7
   AST_OTHER_TYPE_KEEPS_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_valid && !is_fs && !is_fe) |=> $stable(last_vc_q)); // R10

endmodule

// File: tb/fst_frame_sync_tracker_tb.sv
module fst_frame_sync_tracker_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NV = 4;
   localparam int SW = 2 * NV + 1;

   logic clk = 1'b0;
   logic rst_n;
   logic sp_valid;
   logic [5:0] sp_dtype;
   logic [1:0] sp_vc;
   logic perr_valid;
   logic [1:0] perr_vc;
   logic sot_sync_err;
   logic wr_en;
   logic [SW-1:0] wr_data;
   logic [NV-1:0] sync_err, frame_err;
   logic frame_rcvd;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // Reference state
   bit m_in[NV];
   bit m_acc[NV];
   bit [NV-1:0] m_sync, m_ferr;
   bit m_rcvd;
   int m_last;

   always #2.5 clk = ~clk;

   fst_frame_sync_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .sp_dtype(sp_dtype),
      .sp_vc(sp_vc), .perr_valid(perr_valid), .perr_vc(perr_vc),
      .sot_sync_err(sot_sync_err), .wr_en(wr_en), .wr_data(wr_data),
      .sync_err(sync_err), .frame_err(frame_err), .frame_rcvd(frame_rcvd)
   );

   task automatic model_reset();
      for (int c = 0; c < NV; c++) begin m_in[c] = 0; m_acc[c] = 0; end
      m_sync = '0; m_ferr = '0; m_rcvd = 0; m_last = 0;
   endtask

   task automatic model_step();
      bit [NV-1:0] s_sync, s_ferr;
      bit s_rcvd, fs, fe, hit, mk;
      s_sync = '0; s_ferr = '0;
      mk = sp_valid && (sp_dtype == 6'h00 || sp_dtype == 6'h01);
      s_rcvd = sp_valid && sp_dtype == 6'h01;
      for (int c = 0; c < NV; c++) begin
         fs  = sp_valid && sp_dtype == 6'h00 && sp_vc == c;
         fe  = sp_valid && sp_dtype == 6'h01 && sp_vc == c;
         hit = (perr_valid && perr_vc == c) || (sot_sync_err && m_last == c);
         if (sot_sync_err && m_last == c) s_sync[c] = 1;
         if (fe && !m_in[c]) s_sync[c] = 1;
         if (fe && m_in[c] && (m_acc[c] || hit)) s_ferr[c] = 1;
         if (fs) begin m_in[c] = 1; m_acc[c] = hit; end
         else if (fe) begin m_in[c] = 0; m_acc[c] = 0; end
         else m_acc[c] = m_acc[c] || (hit && m_in[c]);
      end
      if (wr_en) begin
         m_rcvd = m_rcvd & ~wr_data[0];
         m_sync = m_sync & ~wr_data[NV:1];
         m_ferr = m_ferr & ~wr_data[2*NV:NV+1];
      end
      m_rcvd = m_rcvd | s_rcvd;
      m_sync = m_sync | s_sync;
      m_ferr = m_ferr | s_ferr;
      if (mk) m_last = int'(sp_vc);
   endtask

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check({tag, " sync_err"}, int'(sync_err), int'(m_sync));
      check({tag, " frame_err"}, int'(frame_err), int'(m_ferr));
      check({tag, " frame_rcvd"}, int'(frame_rcvd), int'(m_rcvd));
   endtask

   task automatic idle_inputs();
      sp_valid = 0; sp_dtype = '0; sp_vc = '0; perr_valid = 0; perr_vc = '0;
      sot_sync_err = 0; wr_en = 0; wr_data = '0;
   endtask

   // Applies current inputs for one clock; compares after the edge.
   task automatic step(string tag);
      model_step();
      @(negedge clk);
      check_all(tag);
      idle_inputs();
   endtask

   task automatic pkt(string tag, int dt, int vc);
      sp_valid = 1; sp_dtype = 6'(dt); sp_vc = 2'(vc);
      step(tag);
   endtask

   task automatic perr(string tag, int vc);
      perr_valid = 1; perr_vc = 2'(vc);
      step(tag);
   endtask

   task automatic clear_all(string tag);
      wr_en = 1; wr_data = '1;
      step(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      idle_inputs();
      rst_n = 0;
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1
      check("R1 sync_err", int'(sync_err), 0);
      check("R1 frame_err", int'(frame_err), 0);
      check("R1 frame_rcvd", int'(frame_rcvd), 0);

      // R2 / R8: clean frame on ch0
      pkt("R2", 0, 0);
      pkt("R2", 1, 0);
      check("R2 no sync ch0", int'(sync_err[0]), 0);
      check("R8 rcvd", int'(frame_rcvd), 1);
      clear_all("R9");

      // R3: error inside frame ch1; idle error on ch2 ignored
      pkt("R3", 0, 1);
      perr("R3", 1);
      pkt("R3", 1, 1);
      check("R3 ferr ch1", int'(frame_err[1]), 1);
      perr("R3", 2);
      pkt("R3", 0, 2);
      pkt("R3", 1, 2);
      check("R3 idle err not counted ch2", int'(frame_err[2]), 0);
      // R3: error in the Frame End cycle itself
      pkt("R3", 0, 2);
      sp_valid = 1; sp_dtype = 6'h01; sp_vc = 2; perr_valid = 1; perr_vc = 2;
      step("R3");
      check("R3 ferr on FE cycle ch2", int'(frame_err[2]), 1);
      clear_all("R9");

      // R4: restart drops earlier error, keeps same-cycle one
      pkt("R4", 0, 3);
      perr("R4", 3);
      pkt("R4", 0, 3);
      pkt("R4", 1, 3);
      check("R4 restart drops err ch3", int'(frame_err[3]), 0);
      pkt("R4", 0, 3);
      sp_valid = 1; sp_dtype = 6'h00; sp_vc = 3; perr_valid = 1; perr_vc = 3;
      step("R4");
      pkt("R4", 1, 3);
      check("R4 same-cycle err kept ch3", int'(frame_err[3]), 1);
      clear_all("R9");

      // R5: FE after FE, FS after FS
      pkt("R5", 0, 0);
      pkt("R5", 1, 0);
      clear_all("R5");
      pkt("R5", 1, 0);
      check("R5 FE-FE sync ch0", int'(sync_err[0]), 1);
      check("R5 FE-FE rcvd", int'(frame_rcvd), 1);
      clear_all("R9");
      pkt("R5", 0, 1);
      pkt("R5", 0, 1);
      pkt("R5", 1, 1);
      check("R5 FS-FS no sync ch1", int'(sync_err[1]), 0);
      clear_all("R9");

      // R6: channels independent
      pkt("R6", 0, 0);
      pkt("R6", 0, 1);
      perr("R6", 1);
      pkt("R6", 1, 0);
      check("R6 ch0 clean", int'(frame_err[0]), 0);
      check("R6 ch1 untouched", int'(frame_err[1]), 0);
      pkt("R6", 1, 1);
      check("R6 ch1 error", int'(frame_err[1]), 1);
      clear_all("R9");

      // R7 / R10: sot charged to last marker channel, other type ignored
      pkt("R7", 0, 2);
      pkt("R10", 6'h12, 3);
      sot_sync_err = 1;
      step("R7");
      check("R7 sot to ch2", int'(sync_err), 4);
      pkt("R7", 1, 2);
      check("R7 sot counts as frame err ch2", int'(frame_err[2]), 1);
      clear_all("R9");
      pkt("R10", 6'h2a, 3);
      pkt("R10", 1, 3);
      check("R10 ch3 still idle", int'(sync_err[3]), 1);
      clear_all("R9");

      // R9: set beats same-cycle clear
      sp_valid = 1; sp_dtype = 6'h01; sp_vc = 0; wr_en = 1; wr_data = '1;
      step("R9");
      check("R9 set wins rcvd", int'(frame_rcvd), 1);
      check("R9 set wins sync ch0", int'(sync_err[0]), 1);
      wr_en = 1; wr_data = 9'h001;
      step("R9");
      check("R9 partial clear", int'({sync_err, frame_rcvd}), 2);
      clear_all("R9");

      // Random traffic against the reference
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 35) begin
            sp_valid = 1;
            r = int'($urandom_range(0, 9));
            sp_dtype = (r < 4) ? 6'h00 : (r < 8) ? 6'h01 : 6'($urandom_range(2, 63));
            sp_vc = 2'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 99) < 20) begin
            perr_valid = 1; perr_vc = 2'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 99) < 5) sot_sync_err = 1;
         if ($urandom_range(0, 99) < 15) begin
            wr_en = 1; wr_data = SW'($urandom);
         end
         step("R6 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule